// File: doc/BRIEF.md
# Phase-Difference Frequency Estimator

This block turns a stream of phase samples into a frequency error estimate. Each accepted 16-bit phase word is written into a short circular store. The word taken the selected number of samples earlier is subtracted from it, with wrap modulo 2^16. A phase difference over a fixed span of samples is proportional to frequency, so a longer span gives a larger gain. The span is a power of two, from one to sixteen samples.

A signed five-bit fractional offset is then added, with wrap, to the five most significant bits of the difference. A left shift of zero to four places scales the result. The shift drops bits off the top and fills zeros at the bottom. Two byte-wide control registers set the span, the offset and the shift. A sticky flag reports any attempt to program a shift code that is out of range. After the span changes, the output stays quiet until the store holds enough new samples for a full-span difference.

Top module: `phase_freq_disc`

## Requirements
- R1: After a synchronous reset, `fe_valid` and `shift_err` are 0 and the three settings are zero: span code 0 (one sample), offset 0 and shift 0.
- R2: For sample n, `fe_data` before offset and shift equals phase(n) − phase(n−D) modulo 2^16. D = 2^K and K is written in bits [2:0] of control register 0 (`cfg_sel`=0). K codes 5, 6 and 7 act as K=4 (D=16).
- R3: A sample accepted at one rising edge produces `fe_valid`=1, with its result on `fe_data`, after the following rising edge. `fe_valid` is 0 between those two edges.
- R4: After reset, and after any write that changes the effective K, the first D accepted samples produce no `fe_valid`. A register 0 write that leaves the effective K the same does not restart this count.
- R5: Bits [7:3] of control register 0 are a two's-complement offset. It is added modulo 32 to bits [15:11] of the difference, and bits [10:0] are not changed.
- R6: Bits [2:0] of control register 1 (`cfg_sel`=1) give a left shift of 0 to 4 places, applied after the offset. Bits shifted out at the top are lost and zeros fill the bottom.
- R7: Writing a shift code of 5, 6 or 7 sets a shift of 0 and sets `shift_err`. The flag stays 1 until reset, even after a later valid shift code is written.
- R8: While `ph_valid` is 0, no result is produced and the store does not advance. The next accepted sample is compared against the samples accepted before the idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ph_valid | input | 1 | Qualifies `ph_data` for one cycle |
| ph_data | input | 16 | Phase sample, full scale is one turn |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | 0 selects the span/offset register, 1 the shift register |
| cfg_wdata | input | 8 | Control write data |
| fe_valid | output | 1 | Qualifies `fe_data` |
| fe_data | output | 16 | Frequency error after offset and shift |
| shift_err | output | 1 | Sticky flag for an out-of-range shift code |

## Verification
Some properties are checked on every cycle by assertions:
- K and the shift never exceed four.
- The error flag never falls outside reset.
- An idle input or a span restart is never followed by a result.
- Every result is preceded one cycle earlier by a difference-stage result.
- A nonzero shift always leaves a zero least significant bit.

Other behaviour can only be shown by the bench's scenarios, because it depends on the arithmetic across sample history: the wrapped differences for each span, the clamp of K codes above four, the fill count after a span change, a rewrite of the offset that leaves the span alone and causes no refill, and the offset carry out of the top five bits.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int FIELD_W = 3;
  localparam int OFS_W   = 5;

  typedef struct packed {
    logic [FIELD_W-1:0] k;
    logic [OFS_W-1:0]   ofs;
    logic [FIELD_W-1:0] sh;
  } pfd_cfg_t;

  // Bound a field: codes above lim map to repl.
  function automatic logic [FIELD_W-1:0] bound_field(
      input logic [FIELD_W-1:0] v,
      input logic [FIELD_W-1:0] lim,
      input logic [FIELD_W-1:0] repl);
    return (v > lim) ? repl : v;
  endfunction
endpackage

// File: rtl/pfd_cfg.sv
module pfd_cfg
  import pfd_pkg::*;
#(
  parameter int KMAX  = 4,
  parameter int SHMAX = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  output pfd_cfg_t   cfg,
  output logic       restart,
  output logic       err
);
  localparam logic [FIELD_W-1:0] KLIM  = FIELD_W'(KMAX);
  localparam logic [FIELD_W-1:0] SHLIM = FIELD_W'(SHMAX);

  logic [FIELD_W-1:0] k_new;
  logic [FIELD_W-1:0] sh_new;
  logic               sh_bad;

  always_comb begin
    k_new  = bound_field(wdata[FIELD_W-1:0], KLIM, KLIM);
    sh_new = bound_field(wdata[FIELD_W-1:0], SHLIM, '0);
    sh_bad = (wdata[FIELD_W-1:0] > SHLIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      restart <= 1'b0;
      err     <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (we && !sel) begin
        restart <= (k_new != cfg.k);
        cfg.k   <= k_new;
        cfg.ofs <= wdata[FIELD_W +: OFS_W];
      end
      if (we && sel) begin
        cfg.sh <= sh_new;
        if (sh_bad) err <= 1'b1;
      end
    end
  end

  assert_k_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cfg.k <= KLIM);
  assert_shift_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cfg.sh <= SHLIM);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err);
endmodule

// File: rtl/pfd_delay.sv
module pfd_delay
  import pfd_pkg::*;
#(
  parameter int PW   = 16,
  parameter int KMAX = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ph_valid,
  input  logic [PW-1:0]      ph_data,
  input  logic [FIELD_W-1:0] k,
  input  logic               restart,
  output logic               diff_v,
  output logic [PW-1:0]      diff_q
);
  localparam int DEPTH = 1 << KMAX;
  localparam int AW    = (KMAX < 1) ? 1 : KMAX;
  localparam int CW    = KMAX + 1;

  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [CW-1:0] fill;
  logic [CW-1:0] span;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] old_ph;

  always_comb begin
    span    = CW'(1) << k;
    rd_addr = wp - AW'(span);
    old_ph  = mem[rd_addr];
  end

  // Storage kept free of reset so it maps to RAM.
  always_ff @(posedge clk) begin
    if (ph_valid) mem[wp] <= ph_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      fill   <= '0;
      diff_v <= 1'b0;
      diff_q <= '0;
    end else begin
      diff_v <= 1'b0;
      if (restart) begin
        fill <= '0;
      end else if (ph_valid) begin
        wp     <= wp + 1'b1;
        diff_v <= (fill >= span);
        diff_q <= ph_data - old_ph;
        if (fill < span) fill <= fill + 1'b1;
      end
    end
  end

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !ph_valid |=> !diff_v);
  assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> !diff_v);
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
endmodule

// File: rtl/pfd_post.sv
module pfd_post
  import pfd_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_v,
  input  logic [PW-1:0]      in_d,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [FIELD_W-1:0] sh,
  output logic               out_v,
  output logic [PW-1:0]      out_d
);
  logic [OFS_W-1:0] top;
  logic [PW-1:0]    merged;
  logic [PW-1:0]    scaled;

  always_comb begin
    top    = in_d[PW-1 -: OFS_W] + ofs;
    merged = {top, in_d[PW-OFS_W-1:0]};
    scaled = merged << sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) out_d <= scaled;
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_v |-> $past(in_v));
  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (out_v && $past(sh) != '0) |-> (out_d[0] == 1'b0));
endmodule

// File: rtl/phase_freq_disc.sv
module phase_freq_disc
  import pfd_pkg::*;
#(
  parameter int PW    = 16,
  parameter int KMAX  = 4,
  parameter int SHMAX = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_valid,
  input  logic [PW-1:0] ph_data,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic          fe_valid,
  output logic [PW-1:0] fe_data,
  output logic          shift_err
);
  pfd_cfg_t      cfg;
  logic          restart;
  logic          diff_v;
  logic [PW-1:0] diff_q;

  pfd_cfg #(.KMAX(KMAX), .SHMAX(SHMAX)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .cfg(cfg), .restart(restart), .err(shift_err)
  );

  pfd_delay #(.PW(PW), .KMAX(KMAX)) u_delay (
    .clk(clk), .rst(rst), .ph_valid(ph_valid), .ph_data(ph_data),
    .k(cfg.k), .restart(restart), .diff_v(diff_v), .diff_q(diff_q)
  );

  pfd_post #(.PW(PW)) u_post (
    .clk(clk), .rst(rst), .in_v(diff_v), .in_d(diff_q),
    .ofs(cfg.ofs), .sh(cfg.sh), .out_v(fe_valid), .out_d(fe_data)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!fe_valid && !shift_err));
endmodule

// File: tb/phase_freq_disc_test.sv
module phase_freq_disc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ph_valid = 1'b0;
  logic [15:0] ph_data = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        fe_valid;
  logic [15:0] fe_data;
  logic        shift_err;

  always #5 clk = ~clk;

  phase_freq_disc uut (
    .clk(clk), .rst(rst), .ph_valid(ph_valid), .ph_data(ph_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fe_valid(fe_valid), .fe_data(fe_data), .shift_err(shift_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] hist [0:511];
  int n = 0;
  int m_k = 0;
  logic [4:0] m_ofs = '0;
  int m_sh = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    if (!sel) begin
      int nk;
      nk = (d[2:0] > 3'd4) ? 4 : int'(d[2:0]);
      if (nk != m_k) n = 0;
      m_k = nk;
      m_ofs = d[7:3];
    end else begin
      m_sh = (d[2:0] > 3'd4) ? 0 : int'(d[2:0]);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] p);
    logic [15:0] diff;
    logic [4:0]  top;
    logic [15:0] merged;
    diff   = p - hist[n - (1 << m_k)];
    top    = diff[15:11] + m_ofs;
    merged = {top, diff[10:0]};
    return merged << m_sh;
  endfunction

  task automatic send(input logic [15:0] p, input string tag);
    logic        ev;
    logic [15:0] ed;
    ev = (n >= (1 << m_k));
    ed = ev ? model(p) : 16'h0;
    @(negedge clk);
    ph_valid = 1'b1; ph_data = p;
    @(negedge clk);
    ph_valid = 1'b0;
    chk({"R3 not yet valid ", tag}, 32'(fe_valid), 32'd0);
    @(negedge clk);
    chk({"valid ", tag}, 32'(fe_valid), 32'(ev));
    if (ev) chk({"data ", tag}, 32'(fe_data), 32'(ed));
    hist[n] = p;
    n++;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fe_valid after reset", 32'(fe_valid), 32'd0);
    chk("R1 shift_err after reset", 32'(shift_err), 32'd0);
    send(16'h1000, "R4 first sample with K=0 gives nothing");
    send(16'h1234, "R1 R2 default span of one");
  endtask

  task automatic test_span(input logic [2:0] k, input int count);
    cfg_write(1'b0, {5'd0, k});
    for (int i = 0; i < count; i++)
      send(16'(i * 7919 + 40000), "R2 R4 span difference with wrap");
  endtask

  task automatic test_offset();
    cfg_write(1'b0, {5'b11111, 3'd1});
    for (int i = 0; i < 4; i++) send(16'(i * 1500 + 300), "R5 offset minus one");
    cfg_write(1'b0, {5'b01111, 3'd1});
    send(16'hF800, "R4 R5 offset rewrite keeps span filled");
    send(16'h7000, "R5 offset top-bit wrap");
  endtask

  task automatic test_shift();
    cfg_write(1'b0, {5'd0, 3'd0});
    send(16'h0100, "R4 refill for shift test");
    cfg_write(1'b1, 8'd3);
    send(16'h2345, "R6 shift of three");
    cfg_write(1'b1, 8'd4);
    send(16'hA000, "R6 shift of four drops MSBs");
    cfg_write(1'b1, 8'd6);
    chk("R7 shift_err set by code 6", 32'(shift_err), 32'd1);
    send(16'h1357, "R7 invalid code acts as no shift");
    cfg_write(1'b1, 8'd2);
    chk("R7 shift_err stays set", 32'(shift_err), 32'd1);
    send(16'h4000, "R6 shift of two");
  endtask

  task automatic test_idle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 no output while idle", 32'(fe_valid), 32'd0);
    end
    send(16'h9999, "R8 history kept across idle gap");
  endtask

  initial begin
    test_reset();
    test_span(3'd0, 4);
    test_span(3'd2, 7);
    test_span(3'd7, 19);
    test_span(3'd4, 3);
    test_span(3'd1, 5);
    test_offset();
    test_shift();
    test_idle();
    wrap_up();
  end
endmodule